// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block gathers the interrupt requests of a small microcontroller and chooses which one the CPU services next. Sixteen fixed priority levels exist, level 15 being the most urgent. Each level owns a vector word address. A request is considered only when the enables that apply to its class allow it. The block latches the winning vector and holds it for the CPU. When the CPU acknowledges, the block pulses a one-hot clear line back to the source that won, so that its peripheral can drop the flag.

Requests fall into three classes. The reset request and the non-maskable event ignore every enable. The oscillator-fault event obeys only its own enable bit. Every other source needs the global enable, and most of them also need a per-source bit. The non-maskable and oscillator-fault events share level 14. Two byte-wide enable registers sit on a simple register bus; bits without a function do not exist in hardware. The global enable is set by a CPU strobe and is cleared by the block when a globally maskable request is accepted.

Top module: `irqv_ctrl`

## Requirements
- R1: A latched vector equals 0xFFE0 + 2 × level, and the highest pending, enabled level is the one chosen (level 15 is the highest, level 0 the lowest).
- R2: A reset request (`rst_req_i`) takes level 15 with vector 0xFFFE, needs no enable, and beats every other request.
- R3: The non-maskable event (`nmi_i`) takes level 14 with vector 0xFFFC and is taken with all enable bits and the global enable at 0.
- R4: The oscillator-fault event (`ofault_i`) takes level 14 only while bit 1 of enable register 0 is set, and the global enable has no effect on it.
- R5: Levels 0–13 need the global enable. Level 13 also needs register-0 bit 6, level 12 register-0 bit 7, level 10 register-0 bit 0, level 7 register-1 bit 0, level 6 register-1 bit 1, level 4 register-1 bit 3 and level 1 register-1 bit 7. Levels 9, 8, 3, 2 and 0 need the global enable only.
- R6: Levels 5 and 11 have no source, and a request on those input bits is never taken.
- R7: Register 0 (address 0) implements bits 0, 1, 6 and 7, and register 1 (address 1) implements bits 0, 1, 3 and 7. The implemented bits can be read and written and reset to 0. Other bits ignore writes and read as 0.
- R8: `valid_o` and `vec_o` change on the clock edge after a qualifying request, and then hold steady until acknowledge, even if a higher request arrives in the meantime.
- R9: While `ack_i` and `valid_o` are both high, `clr_o` is one-hot in that same cycle. Bit k marks level k and bit 16 marks the oscillator fault. `clr_o` is 0 at all other times, and `valid_o` falls at the next edge.
- R10: Acceptance of a level 0–13 request clears the global enable. Acceptance of a level 14 or 15 request leaves it unchanged. `gie_set_i` sets the global enable, and reset clears it.
- R11: If the non-maskable event and an enabled oscillator fault are pending together, the non-maskable event is reported first (clear bit 14).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rst_req_i | input | 1 | Reset request, level 15 |
| nmi_i | input | 1 | Non-maskable event, level 14 |
| ofault_i | input | 1 | Oscillator fault, level 14 |
| lvl_req_i | input | 14 | Request lines, bit k is level k |
| gie_set_i | input | 1 | Strobe that sets the global enable |
| ack_i | input | 1 | CPU acknowledge of the latched vector |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register select |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data (combinational) |
| valid_o | output | 1 | A vector is latched |
| vec_o | output | 16 | Vector word address |
| clr_o | output | 17 | One-hot flag clear, pulsed during acknowledge |

## Verification
A table of request patterns runs the arbiter with single requests, with requests whose enables are missing, and with several requests at once. Comparing the same request with and without the global enable shows the three enable classes apart. Requests on two adjacent levels test the priority order, and requests on the unassigned levels 5 and 11 test that those levels stay dead. Directed sequences raise a higher request while a vector is held, and they also look at what the global enable does after a maskable acceptance and after a level-14 acceptance. Another directed sequence makes the two level-14 sources collide. These cases separate hold-until-acknowledge from re-arbitration, and they show which source the shared vector is cleared for.

// File: rtl/irqv_pkg.sv
// Package irqv_pkg
// Shared constants for the interrupt vector controller: the level count, the
// vector base, the enable-register bit placement and the masks of the
// physically present bits.
package irqv_pkg;
    localparam int NUM_LVL  = 16;
    localparam int LVL_W    = $clog2(NUM_LVL);
    localparam int NUM_SRC  = NUM_LVL + 1;          // level sources plus osc fault
    localparam int SRC_W    = $clog2(NUM_SRC);
    localparam int SRC_OF   = NUM_LVL;              // clear index of osc fault
    localparam int LVL_NMI  = 14;
    localparam int LVL_RST  = 15;
    localparam int VEC_W    = 16;
    localparam logic [VEC_W-1:0] VEC_BASE = 16'hFFE0;
    localparam int REG_W    = 8;
    localparam int NUM_REG  = 2;
    localparam int ADDR_W   = $clog2(NUM_REG);

    // Present bits of each enable register
    localparam logic [REG_W-1:0] IMPL_R0 = 8'hC3;
    localparam logic [REG_W-1:0] IMPL_R1 = 8'h8B;

    // Bit positions in register 0
    localparam int R0_WDT = 0;
    localparam int R0_OF  = 1;
    localparam int R0_P00 = 6;
    localparam int R0_P01 = 7;
    // Bit positions in register 1
    localparam int R1_RX  = 0;
    localparam int R1_TX  = 1;
    localparam int R1_TP  = 3;
    localparam int R1_BT  = 7;

    // Levels that ignore the global enable
    localparam logic [NUM_LVL-1:0] GIE_EXEMPT = 16'hC000;

    // Vector word address for a level
    function automatic logic [VEC_W-1:0] lvl_vector(input logic [LVL_W-1:0] lvl);
        return VEC_BASE + (VEC_W'(lvl) << 1);
    endfunction
endpackage

// File: rtl/irqv_enable_regs.sv
// Module irqv_enable_regs
// Holds the byte-wide interrupt enable registers. Only the bits set in the
// implementation masks exist as flops; the other bits ignore writes and read 0.
// Assumes single-cycle writes and combinational reads.
module irqv_enable_regs
    import irqv_pkg::*;
#(
    parameter logic [NUM_REG-1:0][REG_W-1:0] IMPL = {IMPL_R1, IMPL_R0}
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_i,
    input  logic [ADDR_W-1:0]              addr_i,
    input  logic [REG_W-1:0]               wdata_i,
    output logic [REG_W-1:0]               rdata_o,
    output logic [NUM_REG-1:0][REG_W-1:0]  regs_o
);
    logic [NUM_REG-1:0][REG_W-1:0] regs_q;

    for (genvar r = 0; r < NUM_REG; r++) begin : g_reg
        for (genvar b = 0; b < REG_W; b++) begin : g_bit
            if (IMPL[r][b]) begin : g_ff
                // Store one implemented enable bit
                always_ff @(posedge clk) begin
                    if (!rst_n)
                        regs_q[r][b] <= 1'b0;
                    else if (wr_i && (addr_i == ADDR_W'(r)))
                        regs_q[r][b] <= wdata_i[b];
                end
            end else begin : g_absent
                assign regs_q[r][b] = 1'b0;
            end
        end
    end

    // Return the addressed register
    always_comb begin
        rdata_o = regs_q[addr_i];
    end

    assign regs_o = regs_q;
endmodule

// File: rtl/irqv_qualify.sv
// Module irqv_qualify
// Applies the per-source and global enables to the raw request lines,
// giving one active bit per level. Level 14 merges the non-maskable event
// with the oscillator fault, which obeys only its own enable bit.
module irqv_qualify
    import irqv_pkg::*;
(
    input  logic [NUM_LVL-1:0] req_i,
    input  logic               of_req_i,
    input  logic [REG_W-1:0]   r0_i,
    input  logic [REG_W-1:0]   r1_i,
    input  logic               gie_i,
    output logic [NUM_LVL-1:0] act_o,
    output logic               of_sel_o
);
    logic [NUM_LVL-1:0] ind_en;
    logic               of_ok;

    // Map each level to its individual enable (1 if none in these registers)
    always_comb begin
        ind_en     = '1;
        ind_en[5]  = 1'b0;
        ind_en[11] = 1'b0;
        ind_en[13] = r0_i[R0_P00];
        ind_en[12] = r0_i[R0_P01];
        ind_en[10] = r0_i[R0_WDT];
        ind_en[7]  = r1_i[R1_RX];
        ind_en[6]  = r1_i[R1_TX];
        ind_en[4]  = r1_i[R1_TP];
        ind_en[1]  = r1_i[R1_BT];
    end

    assign of_ok = of_req_i & r0_i[R0_OF];

    for (genvar k = 0; k < NUM_LVL; k++) begin : g_lvl
        if (k == LVL_NMI) begin : g_shared
            assign act_o[k] = req_i[k] | of_ok;
        end else begin : g_plain
            assign act_o[k] = req_i[k] & ind_en[k] & (gie_i | GIE_EXEMPT[k]);
        end
    end

    // Osc fault owns level 14 only when the non-maskable event is absent
    assign of_sel_o = of_ok & ~req_i[LVL_NMI];
endmodule

// File: rtl/irqv_prio_enc.sv
// Module irqv_prio_enc
// Fixed-priority encoder: reports the highest set bit of the active vector.
// Assumes bit N-1 is the most urgent.
module irqv_prio_enc #(
    parameter int N     = 16,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     act_i,
    output logic             any_o,
    output logic [IDX_W-1:0] idx_o
);
    // Scan upward so the highest active bit is the last assignment
    always_comb begin
        any_o = 1'b0;
        idx_o = '0;
        for (int k = 0; k < N; k++) begin
            if (act_i[k]) begin
                any_o = 1'b1;
                idx_o = IDX_W'(k);
            end
        end
    end
endmodule

// File: rtl/irqv_ctrl.sv
// Module irqv_ctrl
// Top of the interrupt vector controller. Qualifies requests, arbitrates
// them, latches the winning vector until acknowledge, pulses the one-hot
// flag clear during the acknowledge cycle and keeps the global enable.
// Assumes request flags stay asserted until their clear pulse is seen.
module irqv_ctrl
    import irqv_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rst_req_i,
    input  logic                 nmi_i,
    input  logic                 ofault_i,
    input  logic [13:0]          lvl_req_i,
    input  logic                 gie_set_i,
    input  logic                 ack_i,
    input  logic                 reg_wr_i,
    input  logic [ADDR_W-1:0]    reg_addr_i,
    input  logic [REG_W-1:0]     reg_wdata_i,
    output logic [REG_W-1:0]     reg_rdata_o,
    output logic                 valid_o,
    output logic [VEC_W-1:0]     vec_o,
    output logic [NUM_SRC-1:0]   clr_o
);
    logic [NUM_REG-1:0][REG_W-1:0] regs;
    logic [NUM_LVL-1:0]            req_all;
    logic [NUM_LVL-1:0]            act;
    logic                          of_sel;
    logic                          any;
    logic [LVL_W-1:0]              win_lvl;
    logic [SRC_W-1:0]              win_src;
    logic                          valid_q;
    logic [VEC_W-1:0]              vec_q;
    logic [SRC_W-1:0]              src_q;
    logic                          gie_q;
    logic                          accept;

    assign req_all = {rst_req_i, nmi_i, lvl_req_i};

    irqv_enable_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (reg_wr_i),
        .addr_i  (reg_addr_i),
        .wdata_i (reg_wdata_i),
        .rdata_o (reg_rdata_o),
        .regs_o  (regs)
    );

    irqv_qualify u_qual (
        .req_i    (req_all),
        .of_req_i (ofault_i),
        .r0_i     (regs[0]),
        .r1_i     (regs[1]),
        .gie_i    (gie_q),
        .act_o    (act),
        .of_sel_o (of_sel)
    );

    irqv_prio_enc #(.N(NUM_LVL)) u_enc (
        .act_i (act),
        .any_o (any),
        .idx_o (win_lvl)
    );

    // Translate the winning level into a clear index
    always_comb begin
        if (win_lvl == LVL_W'(LVL_NMI) && of_sel)
            win_src = SRC_W'(SRC_OF);
        else
            win_src = SRC_W'(win_lvl);
    end

    assign accept = valid_q & ack_i;

    // Latch the winner and hold it until acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            vec_q   <= '0;
            src_q   <= '0;
        end else if (valid_q) begin
            if (ack_i)
                valid_q <= 1'b0;
        end else if (any) begin
            valid_q <= 1'b1;
            vec_q   <= lvl_vector(win_lvl);
            src_q   <= win_src;
        end
    end

    // Keep the global enable: a maskable acceptance clears it
    always_ff @(posedge clk) begin
        if (!rst_n)
            gie_q <= 1'b0;
        else if (accept && (src_q < SRC_W'(LVL_NMI)))
            gie_q <= 1'b0;
        else if (gie_set_i)
            gie_q <= 1'b1;
    end

    // Pulse the clear line of the acknowledged source
    always_comb begin
        clr_o = '0;
        if (accept)
            clr_o = NUM_SRC'(1) << src_q;
    end

    assign valid_o = valid_q;
    assign vec_o   = vec_q;
endmodule

// File: rtl/irqv_checker.sv
// Module irqv_checker
// Temporal properties of the interrupt vector controller, observed at
// its ports only. Attached to every instance of irqv_ctrl by bind.
module irqv_checker
    import irqv_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               rst_req_i,
    input logic               nmi_i,
    input logic               ack_i,
    input logic [ADDR_W-1:0]  reg_addr_i,
    input logic [REG_W-1:0]   reg_rdata_o,
    input logic               valid_o,
    input logic [VEC_W-1:0]   vec_o,
    input logic [NUM_SRC-1:0] clr_o
);
    // R1: a held vector lies in the table and is word aligned
    p_vec_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (vec_o[15:5] == 11'h7FF) && !vec_o[0]);

    // R2: a reset request seen while idle yields the top vector
    p_reset_top_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_req_i && !valid_o) |=> (valid_o && vec_o == 16'hFFFE));

    // R3: the non-maskable event is taken whatever the enables
    p_nmi_taken_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_i && !rst_req_i && !valid_o) |=> (valid_o && vec_o == 16'hFFFC));

    // R7: absent bits read as zero
    p_absent_bits_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rdata_o & ~((reg_addr_i == 1'b0) ? IMPL_R0 : IMPL_R1)) == '0);

    // R8: a held vector stays until acknowledge
    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !ack_i) |=> (valid_o && $stable(vec_o)));

    // R9: at most one clear bit at a time
    p_clr_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(clr_o));

    // R9: a clear only during an acknowledged vector
    p_clr_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_o != '0) |-> (ack_i && valid_o));

    // R9: acknowledge releases the vector
    p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && ack_i) |=> !valid_o);
endmodule

bind irqv_ctrl irqv_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rst_req_i   (rst_req_i),
    .nmi_i       (nmi_i),
    .ack_i       (ack_i),
    .reg_addr_i  (reg_addr_i),
    .reg_rdata_o (reg_rdata_o),
    .valid_o     (valid_o),
    .vec_o       (vec_o),
    .clr_o       (clr_o)
);

// File: tb/irqv_ctrl_test.sv
// Bench for irqv_ctrl: a table of request patterns, then directed cases.
module irqv_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rst_req_i = 1'b0;
    logic        nmi_i = 1'b0;
    logic        ofault_i = 1'b0;
    logic [13:0] lvl_req_i = '0;
    logic        gie_set_i = 1'b0;
    logic        ack_i = 1'b0;
    logic        reg_wr_i = 1'b0;
    logic        reg_addr_i = 1'b0;
    logic [7:0]  reg_wdata_i = '0;
    logic [7:0]  reg_rdata_o;
    logic        valid_o;
    logic [15:0] vec_o;
    logic [16:0] clr_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    irqv_ctrl uut (
        .clk(clk), .rst_n(rst_n), .rst_req_i(rst_req_i), .nmi_i(nmi_i),
        .ofault_i(ofault_i), .lvl_req_i(lvl_req_i), .gie_set_i(gie_set_i),
        .ack_i(ack_i), .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i),
        .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
        .valid_o(valid_o), .vec_o(vec_o), .clr_o(clr_o)
    );

    always #5 clk = ~clk;

    typedef struct packed {
        logic [7:0]  r0;
        logic [7:0]  r1;
        logic        gie;
        logic        rst;
        logic        nmi;
        logic        of;
        logic [13:0] lvl;
        logic        ev;
        logic [15:0] vec;
        logic [4:0]  src;
    } row_t;

    localparam int NROW = 14;
    localparam row_t TABLE [NROW] = '{
        '{8'h00, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 14'h2000, 1'b0, 16'h0000, 5'd0 },  // R5 no enables
        '{8'h40, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 14'h2000, 1'b1, 16'hFFFA, 5'd13},  // R5 R1
        '{8'h40, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 14'h2000, 1'b0, 16'h0000, 5'd0 },  // R5 global off
        '{8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 14'h0000, 1'b1, 16'hFFFC, 5'd14},  // R3
        '{8'h02, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 14'h0000, 1'b1, 16'hFFFC, 5'd16},  // R4 global off
        '{8'h00, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 14'h0000, 1'b0, 16'h0000, 5'd0 },  // R4 own bit off
        '{8'h00, 8'h03, 1'b1, 1'b0, 1'b0, 1'b0, 14'h00C0, 1'b1, 16'hFFEE, 5'd7 },  // R1 order
        '{8'h00, 8'h02, 1'b1, 1'b0, 1'b0, 1'b0, 14'h00C0, 1'b1, 16'hFFEC, 5'd6 },  // R5 level 7 off
        '{8'hFF, 8'hFF, 1'b1, 1'b0, 1'b0, 1'b0, 14'h0820, 1'b0, 16'h0000, 5'd0 },  // R6
        '{8'hFF, 8'hFF, 1'b1, 1'b1, 1'b1, 1'b0, 14'h2000, 1'b1, 16'hFFFE, 5'd15},  // R2 beats all
        '{8'h00, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 14'h0001, 1'b1, 16'hFFE0, 5'd0 },  // R5 level 0
        '{8'h00, 8'h80, 1'b1, 1'b0, 1'b0, 1'b0, 14'h0002, 1'b1, 16'hFFE2, 5'd1 },  // R5 level 1
        '{8'h00, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 14'h0300, 1'b1, 16'hFFF2, 5'd9 },  // R1 R5 levels 9,8
        '{8'h00, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 14'h0000, 1'b1, 16'hFFFE, 5'd15}   // R2 no enables
    };

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; rst_req_i = 1'b0; nmi_i = 1'b0; ofault_i = 1'b0;
        lvl_req_i = '0; gie_set_i = 1'b0; ack_i = 1'b0; reg_wr_i = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr_reg(input logic a, input logic [7:0] d);
        reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
        @(negedge clk);
        reg_wr_i = 1'b0;
    endtask

    task automatic rd_chk(input string rq, input logic a, input logic [7:0] exp);
        reg_addr_i = a;
        #1;
        chk(rq, 32'(reg_rdata_o), 32'(exp));
    endtask

    task automatic pulse_gie();
        gie_set_i = 1'b1;
        @(negedge clk);
        gie_set_i = 1'b0;
    endtask

    // Acknowledge at a negedge, check the clear in that cycle
    task automatic ack_chk(input string rq, input int src);
        ack_i = 1'b1;
        #1;
        chk(rq, 32'(clr_o), 32'(17'd1 << src));
        @(negedge clk);
        ack_i = 1'b0;
        chk(rq, 32'(valid_o), 32'd0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // Reset state: no vector, registers zero, no clear even with ack (R7, R9)
        do_reset();
        ack_i = 1'b1;
        #1;
        chk("R9 reset valid", 32'(valid_o), 32'd0);
        chk("R9 clear without vector", 32'(clr_o), 32'd0);
        ack_i = 1'b0;
        rd_chk("R7 reset reg0", 1'b0, 8'h00);
        rd_chk("R7 reset reg1", 1'b1, 8'h00);

        // Absent bits (R7)
        wr_reg(1'b0, 8'hFF);
        wr_reg(1'b1, 8'hFF);
        rd_chk("R7 reg0 present bits", 1'b0, 8'hC3);
        rd_chk("R7 reg1 present bits", 1'b1, 8'h8B);
        wr_reg(1'b0, 8'h00);
        rd_chk("R7 reg0 cleared", 1'b0, 8'h00);

        // Table walk (R1..R6)
        for (int i = 0; i < NROW; i++) begin
            do_reset();
            wr_reg(1'b0, TABLE[i].r0);
            wr_reg(1'b1, TABLE[i].r1);
            if (TABLE[i].gie) pulse_gie();
            rst_req_i = TABLE[i].rst; nmi_i = TABLE[i].nmi;
            ofault_i = TABLE[i].of; lvl_req_i = TABLE[i].lvl;
            @(negedge clk);
            chk($sformatf("R1 table row %0d valid", i), 32'(valid_o), 32'(TABLE[i].ev));
            if (TABLE[i].ev) begin
                chk($sformatf("R1 table row %0d vector", i), 32'(vec_o), 32'(TABLE[i].vec));
                ack_chk($sformatf("R9 table row %0d clear", i), int'(TABLE[i].src));
            end
            rst_req_i = 1'b0; nmi_i = 1'b0; ofault_i = 1'b0; lvl_req_i = '0;
        end

        // Hold until acknowledge, then maskable acceptance drops the global enable (R8, R10)
        do_reset();
        wr_reg(1'b0, 8'h40);
        wr_reg(1'b1, 8'h02);
        pulse_gie();
        lvl_req_i = 14'h0040;
        @(negedge clk);
        chk("R8 first vector", 32'(vec_o), 32'hFFEC);
        lvl_req_i = 14'h2040;
        repeat (2) @(negedge clk);
        chk("R8 held despite higher", 32'(vec_o), 32'hFFEC);
        chk("R8 still valid", 32'(valid_o), 32'd1);
        ack_chk("R9 clear level 6", 6);
        lvl_req_i = 14'h2000;
        repeat (2) @(negedge clk);
        chk("R10 global cleared by acceptance", 32'(valid_o), 32'd0);
        pulse_gie();
        @(negedge clk);
        chk("R10 global set again", 32'(vec_o), 32'hFFFA);
        ack_chk("R10 clear level 13", 13);
        lvl_req_i = '0;

        // Level-14 acceptance keeps the global enable (R3, R10)
        do_reset();
        wr_reg(1'b0, 8'h40);
        pulse_gie();
        nmi_i = 1'b1;
        @(negedge clk);
        chk("R3 nmi vector", 32'(vec_o), 32'hFFFC);
        ack_chk("R3 nmi clear", 14);
        nmi_i = 1'b0;
        lvl_req_i = 14'h2000;
        repeat (2) @(negedge clk);
        chk("R10 global kept after nmi", 32'(vec_o), 32'hFFFA);
        chk("R10 maskable taken after nmi", 32'(valid_o), 32'd1);
        lvl_req_i = '0;

        // Both level-14 sources at once (R11, R4)
        do_reset();
        wr_reg(1'b0, 8'h02);
        nmi_i = 1'b1; ofault_i = 1'b1;
        @(negedge clk);
        chk("R11 shared vector", 32'(vec_o), 32'hFFFC);
        ack_chk("R11 nmi cleared first", 14);
        nmi_i = 1'b0;
        @(negedge clk);
        chk("R4 osc fault next", 32'(vec_o), 32'hFFFC);
        ack_chk("R4 osc fault clear", 16);
        ofault_i = 1'b0;

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule